// File: doc/BRIEF.md
# Clock Test Output Selector

This debug block routes one selected clock source to a clock probe pin and one selected clock-valid flag to a status probe pin. Software programs a single 32-bit control word over a simple write/read bus. That word holds three things: a clock select, a status select and a 4-bit arming key. The probe pins come alive only while the key holds the arming value 5h. In every other state, and for any select code that has no source behind it, the pins are held low.

The clock sources and the valid flags arrive as two 16-bit vectors. Each vector is indexed by select code, so bit N carries the source for code N. Bits that have no listed source are masked off inside the block, so a level on a reserved input bit can never reach a pin. Writes take effect only when the bus marks them as privileged.

Top module: `clk_probe_mux`

## Requirements
- R1: After reset the control word reads 0x000A_0000. The key field (bits 19:16) holds Ah, and both probe pins are low.
- R2: A privileged write stores four fields: bits 3:0 (clock select), bits 11:8 (status select), bits 19:16 (key) and bits 26:24 (spare). All other read-back bits are zero, and the new value is readable in the cycle after the write edge.
- R3: A write with the privilege qualifier low is ignored, and the control word keeps its prior value.
- R4: Test mode is active only while the key equals 5h. With any other key, both probe pins are low whatever the selects and inputs are.
- R5: In test mode, the clock pin equals clk_src[code] for clock select codes 0, 1, 3, 4, 5, 6, 7, 8 and 9.
- R6: Clock select codes 2 and 10 to 15 drive the clock pin low, even when the matching clk_src bit is high.
- R7: In test mode, the status pin equals src_valid[code] for status select codes 0, 1, 5, 6 and 8.
- R8: Every other status select code drives the status pin low, even when the matching src_valid bit is high.
- R9: The spare bits 26:24 have no effect on either probe pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_priv | input | 1 | Access is privileged |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Control word read-back |
| clk_src | input | 16 | Clock sources, indexed by clock select code |
| src_valid | input | 16 | Source-valid flags, indexed by status select code |
| clk_probe | output | 1 | Selected clock out |
| sts_probe | output | 1 | Selected valid flag out |

## Verification
The bench drives every input bit high while it sweeps each reserved code. A design that forgets the mask would leak that level onto a pin, and the sweep would see it. Keys one bit away from 5h, such as 4h, 7h and Dh, catch a partial compare on the key. An unprivileged write carries data that differs in every field, so a missing qualifier would show up as a changed read-back. The spare bits are toggled while both pins are watched, which catches any decode that wrongly reads those bits.

// File: rtl/clk_probe_pkg.sv
// Package: shared field positions, masks and code maps for the clock probe.
// Assumes 4-bit select and key fields inside a 32-bit control word.
package clk_probe_pkg;
    localparam int SEL_W      = 4;
    localparam int NUM_CODES  = 1 << SEL_W;
    localparam int WORD_W     = 32;

    localparam int CSEL_LSB   = 0;
    localparam int SSEL_LSB   = 8;
    localparam int KEY_LSB    = 16;

    localparam logic [SEL_W-1:0]  KEY_ARM    = 4'h5;
    localparam logic [WORD_W-1:0] WORD_RESET = 32'h000A_0000;
    localparam logic [WORD_W-1:0] WORD_MASK  = 32'h070F_0F0F;

    // Bit N set when clock select code N has a source behind it.
    localparam logic [NUM_CODES-1:0] CLK_CODES = 16'b0000_0011_1111_1011;
    // Bit N set when status select code N has a valid flag behind it.
    localparam logic [NUM_CODES-1:0] STS_CODES = 16'b0000_0001_0110_0011;
endpackage

// File: rtl/clk_probe_ctrl.sv
// Control word register for the clock probe.
// Holds only the writable fields and reads reserved bits back as zero.
// Assumes writes are single-cycle strobes. Only privileged writes take effect.
module clk_probe_ctrl
    import clk_probe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              priv,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] word,
    output logic              test_on
);
    logic [WORD_W-1:0] word_q;

    // Load the masked write data on a privileged write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word_q <= WORD_RESET;
        else if (wr && priv)
            word_q <= wdata & WORD_MASK;
    end

    // Decode the arming key.
    always_comb begin
        test_on = (word_q[KEY_LSB +: SEL_W] == KEY_ARM);
    end

    assign word = word_q;

    a_r2_priv_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && priv) |=> (word == ($past(wdata) & WORD_MASK)));
    a_r3_unpriv_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !priv) |=> $stable(word));
endmodule

// File: rtl/clk_probe_sel.sv
// Code-indexed one-of-N selector for a probe pin.
// Codes whose CODE_MASK bit is clear are forced low.
// Assumes the select is stable while it is being used. No glitch control.
module clk_probe_sel #(
    parameter int SEL_W = 4,
    parameter int NUM   = 1 << SEL_W,
    parameter logic [NUM-1:0] CODE_MASK = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    input  logic [NUM-1:0]   src,
    output logic             pin
);
    logic [NUM-1:0] gated;

    // Mask off inputs at reserved codes.
    for (genvar i = 0; i < NUM; i++) begin : g_gate
        assign gated[i] = src[i] & CODE_MASK[i];
    end

    // Pick the selected source when enabled.
    always_comb begin
        pin = en & gated[sel];
    end

    a_r6_r8_reserved_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!CODE_MASK[sel]) |-> !pin);
endmodule

// File: rtl/clk_probe_mux.sv
// Top of the clock probe.
// Holds the control word and drives the clock and status probe pins from it.
// Assumes clk_src and src_valid are indexed by select code.
module clk_probe_mux
    import clk_probe_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_priv,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [15:0] clk_src,
    input  logic [15:0] src_valid,
    output logic        clk_probe,
    output logic        sts_probe
);
    logic [WORD_W-1:0] word;
    logic              test_on;

    clk_probe_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .priv(bus_priv),
        .wdata(bus_wdata), .word(word), .test_on(test_on)
    );

    clk_probe_sel #(.SEL_W(SEL_W), .NUM(NUM_CODES), .CODE_MASK(CLK_CODES)) u_clk_sel (
        .clk(clk), .rst_n(rst_n), .en(test_on),
        .sel(word[CSEL_LSB +: SEL_W]), .src(clk_src), .pin(clk_probe)
    );

    clk_probe_sel #(.SEL_W(SEL_W), .NUM(NUM_CODES), .CODE_MASK(STS_CODES)) u_sts_sel (
        .clk(clk), .rst_n(rst_n), .en(test_on),
        .sel(word[SSEL_LSB +: SEL_W]), .src(src_valid), .pin(sts_probe)
    );

    assign bus_rdata = word;

    a_r4_disarmed_low: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata[19:16] != 4'h5) |-> (!clk_probe && !sts_probe));
endmodule

// File: tb/tb_clk_probe_mux.sv
module tb_clk_probe_mux;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_priv = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] clk_src = '0;
    logic [15:0] src_valid = '0;
    logic        clk_probe;
    logic        sts_probe;
    int          n_run = 0;
    int          n_fail = 0;

    always #2 clk = ~clk;

    clk_probe_mux dut (.*);

    function automatic bit clk_listed(int c);
        return (c == 0 || c == 1 || (c >= 3 && c <= 9));
    endfunction

    function automatic bit sts_listed(int c);
        return (c == 0 || c == 1 || c == 5 || c == 6 || c == 8);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_word(logic [31:0] d, logic p);
        @(negedge clk);
        bus_wr = 1'b1; bus_priv = p; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_priv = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        clk_src = '1; src_valid = '1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 word", bus_rdata, 32'h000A_0000);
        chk("R1 clk_probe", {31'd0, clk_probe}, 32'd0);
        chk("R1 sts_probe", {31'd0, sts_probe}, 32'd0);
    endtask

    task automatic t_priv_write();
        wr_word(32'hFFFF_FFFF, 1'b1);
        chk("R2 all ones", bus_rdata, 32'h070F_0F0F);
        wr_word(32'h0205_0103, 1'b1);
        chk("R2 pattern", bus_rdata, 32'h0205_0103);
    endtask

    task automatic t_unpriv();
        wr_word(32'h050A_0E0C, 1'b0);
        chk("R3 ignored", bus_rdata, 32'h0205_0103);
    endtask

    task automatic t_key();
        logic [3:0] keys [5] = '{4'h4, 4'h7, 4'hD, 4'hA, 4'h0};
        clk_src = '1; src_valid = '1;
        foreach (keys[i]) begin
            wr_word({12'h000, keys[i], 16'h0100}, 1'b1);
            chk("R4 clk off", {31'd0, clk_probe}, 32'd0);
            chk("R4 sts off", {31'd0, sts_probe}, 32'd0);
        end
        wr_word(32'h0005_0100, 1'b1);
        chk("R4 armed clk", {31'd0, clk_probe}, 32'd1);
        chk("R4 armed sts", {31'd0, sts_probe}, 32'd1);
    endtask

    task automatic t_clk_codes();
        for (int c = 0; c < 16; c++) begin
            wr_word(32'h0005_0000 | c, 1'b1);
            clk_src = 16'h0001 << c; #1;
            chk(clk_listed(c) ? "R5 clk hi" : "R6 clk reserved",
                {31'd0, clk_probe}, {31'd0, clk_listed(c)});
            clk_src = ~(16'h0001 << c); #1;
            chk("R5 clk lo", {31'd0, clk_probe}, 32'd0);
        end
    endtask

    task automatic t_sts_codes();
        for (int c = 0; c < 16; c++) begin
            wr_word(32'h0005_0000 | (c << 8), 1'b1);
            src_valid = 16'h0001 << c; #1;
            chk(sts_listed(c) ? "R7 sts hi" : "R8 sts reserved",
                {31'd0, sts_probe}, {31'd0, sts_listed(c)});
            src_valid = ~(16'h0001 << c); #1;
            chk("R7 sts lo", {31'd0, sts_probe}, 32'd0);
        end
    endtask

    task automatic t_spare();
        clk_src = 16'h0010; src_valid = 16'h0020;
        wr_word(32'h0005_0504, 1'b1);
        chk("R9 base clk", {31'd0, clk_probe}, 32'd1);
        for (int s = 1; s < 8; s++) begin
            wr_word(32'h0005_0504 | (s << 24), 1'b1);
            chk("R9 clk", {31'd0, clk_probe}, 32'd1);
            chk("R9 sts", {31'd0, sts_probe}, 32'd1);
        end
        wr_word(32'h0700_0504, 1'b1);
        chk("R9 spare no arm", {31'd0, clk_probe | sts_probe}, 32'd0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_priv_write();
                t_unpriv();
                t_key();
                t_clk_codes();
                t_sts_codes();
                t_spare();
            end
            begin
                repeat (20000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule